// File: doc/BRIEF.md
# UART Interrupt Source and Mask Unit

This unit gathers the interrupt events of one serial port channel into a four-bit raw source register. A mask register gates that raw register into a masked pending value, and one level-sensitive interrupt line goes high whenever any unmasked source is pending. The receive, error, transmit and modem logic each raise their bit with a one-cycle set pulse. Software clears bits by writing ones to either the pending view or the raw source view.

The unit also raises the transmit source without any pulse. When FIFO mode is on and the transmit FIFO occupancy is at or below a trigger level, the transmit bit is set again in every such cycle. The trigger level is a three-bit field in the unit's FIFO control register, multiplied by a factor fixed by the channel kind parameter. Registers are reached through single-cycle write and read strobes with a byte offset. Reads have no side effects and return data in the same cycle.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Offsets: 0x0 FIFO control, 0x4 masked pending (read) and clear (write), 0x8 raw source, 0xC mask. Any other offset reads zero.
- R2: A pulse on `rx_evt`, `err_evt`, `tx_evt` or `modem_evt` sets raw source bit 0, 1, 2 or 3 at the next clock edge. The bit stays set until it is cleared.
- R3: A read at offset 0x4 returns the raw source register ANDed with the inverse of the mask register, in bits 3:0.
- R4: `irq` is high exactly when the masked pending value is nonzero.
- R5: Writing offset 0x4 clears every raw source bit written as 1 and keeps the others.
- R6: Writing offset 0x8 clears every raw source bit written as 1 and keeps the others.
- R7: Writing offset 0xC replaces the mask with `wdata[3:0]`. `irq` follows the new mask from the next cycle.
- R8: The FIFO control register holds the FIFO enable in bit 0 and the trigger field in bits 10:8. Its other bits read as zero. While the FIFO enable is set and `tx_fifo_cnt` is less than or equal to the scaled level, raw bit 2 is set at each clock edge.
- R9: The scaled level is the trigger field times 32 for channel kind 0, times 8 for kinds 1 and 4, and times 2 for kinds 2 and 3. Any other kind gives level 0.
- R10: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, same cycle, zero when `rd_en` is low |
| rx_evt | input | 1 | Receive event set pulse |
| err_evt | input | 1 | Error event set pulse |
| tx_evt | input | 1 | Transmitted-byte set pulse |
| modem_evt | input | 1 | Modem event set pulse |
| tx_fifo_cnt | input | CNT_W | Transmit FIFO occupancy |
| irq | output | 1 | Level interrupt request |

## Verification
Three copies of the unit run side by side: channel kinds 0, 2 and 7. Because they share every input, any difference in transmit-bit behaviour comes from the level scaling alone. Directed sequences cover the reset state and each event bit alone. They also cover masking of a pending bit and clearing through both the pending and source offsets. Further directed cases cover a set pulse colliding with a clear, and FIFO counts one step either side of each kind's level, so an off-by-one in the comparison or a wrong multiplier shows up. A seeded random mix of writes, events and counts then exercises the interaction of sets, clears, mask changes and control changes against a bench model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int SRC_N      = 4;
    localparam int SRC_RX     = 0;
    localparam int SRC_ERR    = 1;
    localparam int SRC_TX     = 2;
    localparam int SRC_MODEM  = 3;

    localparam int CTRL_FEN_BIT  = 0;
    localparam int CTRL_TRIG_LSB = 8;
    localparam int TRIG_W        = 3;

    typedef enum logic [3:0] {
        OFF_CTRL = 4'h0,
        OFF_PEND = 4'h4,
        OFF_SRC  = 4'h8,
        OFF_MASK = 4'hC
    } reg_off_e;

    function automatic int unsigned level_mult(input int unsigned kind);
        case (kind)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_txtrig.sv
module uart_irq_txtrig
    import uart_irq_pkg::*;
#(
    parameter int unsigned CHAN_KIND = 0,
    parameter int          CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [TRIG_W-1:0] trig_field,
    input  logic [CNT_W-1:0]  tx_cnt,
    output logic              tx_hit
);

    localparam int unsigned MULT  = level_mult(CHAN_KIND);
    localparam int          LVL_W = TRIG_W + 6;
    localparam int          CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    logic [LVL_W-1:0] level;

    generate
        if (MULT == 0) begin : g_no_level
            assign level = '0;
        end else begin : g_scaled
            assign level = LVL_W'(trig_field) * LVL_W'(MULT);
        end
    endgenerate

    assign tx_hit = fifo_en && (CMP_W'(tx_cnt) <= CMP_W'(level));

    AST_EMPTY_FIFO_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && tx_cnt == '0) |-> tx_hit); // R8

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && CMP_W'(tx_cnt) > CMP_W'(7 * MULT)) |-> !tx_hit); // R9

endmodule

// File: rtl/uart_irq_srcreg.sv
module uart_irq_srcreg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] src_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= (src_q & ~clr_i) | set_i;
        end
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((src_q & $past(set_i)) == $past(set_i))); // R10

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((src_q & $past(clr_i & ~set_i)) == '0)); // R6

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_irq_pkg::*;
#(
    parameter int unsigned CHAN_KIND = 0,
    parameter int          CNT_W     = 8,
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rx_evt,
    input  logic              err_evt,
    input  logic              tx_evt,
    input  logic              modem_evt,
    input  logic [CNT_W-1:0]  tx_fifo_cnt,
    output logic              irq
);

    logic              fen_q;
    logic [TRIG_W-1:0] trig_q;
    logic [SRC_N-1:0]  mask_q;
    logic [SRC_N-1:0]  src_q;
    logic [SRC_N-1:0]  set_v;
    logic [SRC_N-1:0]  clr_v;
    logic [SRC_N-1:0]  pend;
    logic              tx_hit;
    logic              hit_ctrl, hit_pend, hit_src, hit_mask;
    logic              unused_wdata;

    assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
    assign hit_pend = (addr == ADDR_W'(OFF_PEND));
    assign hit_src  = (addr == ADDR_W'(OFF_SRC));
    assign hit_mask = (addr == ADDR_W'(OFF_MASK));
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fen_q  <= 1'b0;
            trig_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (hit_ctrl) begin
                fen_q  <= wdata[CTRL_FEN_BIT];
                trig_q <= wdata[CTRL_TRIG_LSB +: TRIG_W];
            end
            if (hit_mask) begin
                mask_q <= wdata[SRC_N-1:0];
            end
        end
    end

    uart_irq_txtrig #(.CHAN_KIND(CHAN_KIND), .CNT_W(CNT_W)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fen_q),
        .trig_field (trig_q),
        .tx_cnt     (tx_fifo_cnt),
        .tx_hit     (tx_hit)
    );

    always_comb begin
        set_v            = '0;
        set_v[SRC_RX]    = rx_evt;
        set_v[SRC_ERR]   = err_evt;
        set_v[SRC_TX]    = tx_evt | tx_hit;
        set_v[SRC_MODEM] = modem_evt;
        clr_v = (wr_en && (hit_pend || hit_src)) ? wdata[SRC_N-1:0] : '0;
    end

    uart_irq_srcreg #(.N(SRC_N)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .src_q (src_q)
    );

    assign pend = src_q & ~mask_q;
    assign irq  = |pend;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit_ctrl) begin
                rdata[CTRL_FEN_BIT]                 = fen_q;
                rdata[CTRL_TRIG_LSB +: TRIG_W]      = trig_q;
            end else if (hit_pend) begin
                rdata[SRC_N-1:0] = pend;
            end else if (hit_src) begin
                rdata[SRC_N-1:0] = src_q;
            end else if (hit_mask) begin
                rdata[SRC_N-1:0] = mask_q;
            end
        end
    end

    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_mask && (&wdata[SRC_N-1:0])) |=> !irq); // R7

    AST_TX_THRESHOLD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit |=> src_q[SRC_TX]); // R8

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_pend && !rx_evt && wdata[SRC_RX]) |=> !src_q[SRC_RX]); // R5

endmodule

// File: tb/uart_irq_unit_tb_top.sv
module uart_irq_unit_tb_top;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              rx_evt = 1'b0, err_evt = 1'b0, tx_evt = 1'b0, modem_evt = 1'b0;
    logic [CNT_W-1:0]  tx_fifo_cnt = '0;
    logic [DATA_W-1:0] rd_k[3];
    logic              irq_k[3];

    always #5 clk = ~clk;

    uart_irq_unit #(.CHAN_KIND(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rd_k[0]), .rx_evt(rx_evt), .err_evt(err_evt),
        .tx_evt(tx_evt), .modem_evt(modem_evt), .tx_fifo_cnt(tx_fifo_cnt), .irq(irq_k[0]));
    uart_irq_unit #(.CHAN_KIND(2)) dut_k2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rd_k[1]), .rx_evt(rx_evt), .err_evt(err_evt),
        .tx_evt(tx_evt), .modem_evt(modem_evt), .tx_fifo_cnt(tx_fifo_cnt), .irq(irq_k[1]));
    uart_irq_unit #(.CHAN_KIND(7)) dut_k7 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rd_k[2]), .rx_evt(rx_evt), .err_evt(err_evt),
        .tx_evt(tx_evt), .modem_evt(modem_evt), .tx_fifo_cnt(tx_fifo_cnt), .irq(irq_k[2]));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [3:0] m_src[3];
    logic [3:0] m_mask;
    logic       m_fen;
    logic [2:0] m_trig;

    function automatic int bmult(input int k);
        case (k)
            0: return 32;
            1: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int k, input logic [3:0] a);
        logic [31:0] v = '0;
        case (a)
            4'h0: begin v[0] = m_fen; v[10:8] = m_trig; end
            4'h4: v[3:0] = m_src[k] & ~m_mask;
            4'h8: v[3:0] = m_src[k];
            4'hC: v[3:0] = m_mask;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 3; k++) m_src[k] = '0;
        m_mask = '0; m_fen = 1'b0; m_trig = '0;
    endtask

    // one clock: drive at negedge, model the edge, release strobes after it
    task automatic step(input bit w, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] ev, input int cnt);
        logic [3:0] clr;
        logic [3:0] setv;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; rd_en = 1'b0;
        rx_evt = ev[0]; err_evt = ev[1]; tx_evt = ev[2]; modem_evt = ev[3];
        tx_fifo_cnt = CNT_W'(cnt);
        @(posedge clk);
        clr = (w && (a == 4'h4 || a == 4'h8)) ? d[3:0] : 4'h0;
        for (int k = 0; k < 3; k++) begin
            setv = ev;
            if (m_fen && cnt <= int'(m_trig) * bmult(k)) setv[2] = 1'b1;
            m_src[k] = (m_src[k] & ~clr) | setv;
        end
        if (w && a == 4'hC) m_mask = d[3:0];
        if (w && a == 4'h0) begin m_fen = d[0]; m_trig = d[10:8]; end
        #1;
        wr_en = 1'b0; rx_evt = 0; err_evt = 0; tx_evt = 0; modem_evt = 0;
    endtask

    task automatic chk_irq(input string req);
        for (int k = 0; k < 3; k++)
            check(req, {31'b0, irq_k[k]}, {31'b0, |(m_src[k] & ~m_mask)});
    endtask

    task automatic chk_rd(input string req, input logic [3:0] a);
        rd_en = 1'b1; addr = a; #1;
        for (int k = 0; k < 3; k++) check(req, rd_k[k], exp_read(k, a));
        rd_en = 1'b0; #1;
    endtask

    initial begin
        int seed = 32'h1d5e_0a77;
        int dummy = $urandom(seed);
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk_irq("R1 irq after reset");
        chk_rd("R1 ctrl", 4'h0); chk_rd("R1 pend", 4'h4);
        chk_rd("R1 src", 4'h8);  chk_rd("R1 mask", 4'hC);
        chk_rd("R1 unmapped", 4'h2);
        @(negedge clk); rst_n = 1'b1;

        // R2 each event bit
        step(0, 4'h0, 0, 4'b0001, 0); chk_rd("R2 rx bit0", 4'h8); chk_irq("R4 rx pending");
        step(0, 4'h0, 0, 4'b0010, 0); chk_rd("R2 err bit1", 4'h8);
        step(0, 4'h0, 0, 4'b0100, 0); chk_rd("R2 tx bit2", 4'h8);
        step(0, 4'h0, 0, 4'b1000, 0); chk_rd("R2 modem bit3", 4'h8);
        // R7 mask, R3 pending view
        step(1, 4'hC, 32'hFFFF_FFF5, 0, 0); chk_rd("R7 mask value", 4'hC);
        chk_rd("R3 masked pending", 4'h4); chk_irq("R4 partial mask");
        step(1, 4'hC, 32'hF, 0, 0); chk_irq("R7 full mask drops irq");
        chk_rd("R3 all masked", 4'h4);
        // R5 clear via pending, R6 clear via source
        step(1, 4'h4, 32'h5, 0, 0); chk_rd("R5 pend-write clear", 4'h8);
        step(1, 4'hC, 32'h0, 0, 0); chk_irq("R4 unmasked again");
        step(1, 4'h8, 32'h2, 0, 0); chk_rd("R6 src-write clear", 4'h8);
        step(1, 4'h8, 32'hF, 0, 0); chk_rd("R6 clear all", 4'h8); chk_irq("R4 idle low");
        // R10 set wins over clear
        step(1, 4'h8, 32'hF, 4'b1001, 0); chk_rd("R10 set beats clear", 4'h8);
        step(1, 4'h4, 32'hF, 4'b0010, 0); chk_rd("R10 set beats pend clear", 4'h8);
        step(1, 4'h8, 32'hF, 0, 0);
        // R8 ctrl readback, other bits dropped
        step(1, 4'h0, 32'hFFFF_F1F1, 0, 200); chk_rd("R8 ctrl readback", 4'h0);
        // field=1: levels 32, 2, 0
        step(1, 4'h8, 32'hF, 0, 33); chk_rd("R9 clear while above levels", 4'h8);
        step(0, 4'h0, 0, 0, 33); chk_rd("R9 count 33 no hit", 4'h8);
        step(0, 4'h0, 0, 0, 32); chk_rd("R9 kind0 count 32 at level", 4'h8);
        step(1, 4'h8, 32'hF, 0, 3); chk_rd("R9 count 3", 4'h8);
        step(1, 4'h8, 32'hF, 0, 2); chk_rd("R9 kind2 count 2 at level", 4'h8);
        step(1, 4'h8, 32'hF, 0, 1); chk_rd("R9 count 1", 4'h8);
        step(1, 4'h8, 32'hF, 0, 0); chk_rd("R9 count 0 every kind", 4'h8);
        step(1, 4'h8, 32'hF, 0, 0); chk_rd("R8 re-asserted after clear", 4'h8);
        step(1, 4'h0, 32'h0000_0100, 0, 0); step(1, 4'h8, 32'hF, 0, 0);
        step(0, 4'h0, 0, 0, 0); chk_rd("R8 disabled no hit", 4'h8);
        step(1, 4'h0, 32'h0000_0701, 0, 224); step(1, 4'h8, 32'hF, 0, 224);
        chk_rd("R9 kind0 max level 224", 4'h8);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            logic [31:0] d;
            logic [3:0] ev;
            int cnt;
            case ($urandom % 4)
                0: a = 4'h0; 1: a = 4'h4; 2: a = 4'h8; default: a = 4'hC;
            endcase
            d = $urandom;
            ev = '0;
            for (int b = 0; b < 4; b++) ev[b] = (($urandom % 6) == 0);
            cnt = (($urandom % 2) == 0) ? int'($urandom % 20) : int'($urandom % 256);
            step(($urandom % 3) == 0, a, d, ev, cnt);
            chk_irq("R4 random irq");
            if ((i % 4) == 0) chk_rd("R3 random pend", 4'h4);
            if ((i % 4) == 1) chk_rd("R2 random src", 4'h8);
            if ((i % 8) == 2) chk_rd("R7 random mask", 4'hC);
            if ((i % 8) == 6) chk_rd("R8 random ctrl", 4'h0);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(1_000_000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule